// File: doc/BRIEF.md
# Queue Barrier Blocking Controller

This controller sits in front of one command queue and decides, cycle by cycle, whether the packet at the head of the queue may be dispatched. It tracks three blocking conditions. In the first, the queue is open. In the second, a dispatched packet carried an ordering flag, and the queue waits until the last outstanding packet reports completion. In the third, a barrier packet was taken, and the queue waits until that barrier resolves. Packets may complete out of order. The completion source therefore marks the completion that leaves nothing outstanding, and only that completion releases an ordering-flag hold.

A barrier packet names up to five dependency signals. The controller issues one read request per signal, one per cycle. Responses may return in any order, and a pending counter tracks them. Each evaluation starts with every stored value at 1. The barrier resolves when the last response has returned and every named signal reads 0. If any signal is non-zero, the controller waits a back-off interval and reads all the signals again.

An unmap request forces the queue open at once and clears the pending count. Responses still in flight after an unmap are drained and dropped. A new barrier packet is refused until the drain has finished.

Queue states, encoded 0/1/2: `Q_OPEN`, `Q_HOLD_BIT`, `Q_HOLD_PKT`. Inside `Q_HOLD_PKT` there are two phases, `PH_GATHER` and `PH_BACKOFF`.

Transitions:
- `Q_OPEN` to `Q_HOLD_PKT` on an accepted barrier packet.
- `Q_OPEN` to `Q_HOLD_BIT` on an accepted flagged packet.
- `Q_HOLD_BIT` to `Q_OPEN` on a last completion.
- `PH_GATHER` to `Q_OPEN` when all reads have returned and every value is 0.
- `PH_GATHER` to `PH_BACKOFF` when all reads have returned and some value is non-zero.
- `PH_BACKOFF` to `PH_GATHER` when the back-off timer expires.
- Any state to `Q_OPEN` on unmap.

The read gatherer has its own states:
- `G_IDLE` to `G_ISSUE` or `G_COLLECT` on a start.
- `G_ISSUE` to `G_COLLECT` after the last request.
- Any state to `G_IDLE` on unmap.

Top module: `qbar_ctrl`

## Requirements
- R1: After reset the queue is open and `disp_en`, `rd_req` and `bar_met` are low. In the open state a valid packet is accepted, with `disp_en` high in the same cycle, when its type is 1 (kernel), 2 (barrier) or 3 (agent). Type 0 (invalid) is never accepted.
- R2: An accepted type 1 or 3 packet with `pkt_barrier` high blocks all dispatch. The block lifts only after a cycle with `done_valid` and `done_last` both high, and dispatch resumes in the following cycle. Completions with `done_last` low do not release it.
- R3: An accepted barrier packet blocks dispatch. Starting in the next cycle, it issues one `rd_req` per cycle with `rd_idx` counting 0, 1, …, N-1, where N is `pkt_nsig`.
- R4: `bar_met` is high for one cycle when every response of the current evaluation has returned and every named signal value is 0. It is never high while a response is still pending. The queue is open from the next cycle.
- R5: If any named value is non-zero once all responses have returned, `bar_met` stays low. After a back-off of about RETRY cycles all N reads are issued again, starting from stored values of 1.
- R6: A barrier naming 0 signals resolves, with `bar_met` high, in the cycle after it is accepted. A `pkt_nsig` above MAX_SIG (5) is treated as MAX_SIG.
- R7: `unmap` returns the queue to the open state in the next cycle, clears the pending count and stops further read requests. A kernel packet is accepted in the cycle after an unmap.
- R8: Responses outstanding at an unmap are dropped as they return. Barrier packets are refused until all of them have drained.
- R9: A packet offered in the same cycle as `unmap` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A head packet is offered |
| pkt_type | input | 2 | 0 invalid, 1 kernel, 2 barrier, 3 agent |
| pkt_barrier | input | 1 | Ordering flag of a type 1 or type 3 packet |
| pkt_nsig | input | 3 | Number of dependency signals a barrier names |
| done_valid | input | 1 | A dispatched packet completed |
| done_last | input | 1 | That completion leaves no packet outstanding |
| unmap | input | 1 | Queue unmap request |
| rsp_valid | input | 1 | Signal read response valid |
| rsp_idx | input | 3 | Signal slot of the response |
| rsp_data | input | 32 | Signal value returned |
| rd_req | output | 1 | Signal read request |
| rd_idx | output | 3 | Signal slot requested |
| disp_en | output | 1 | Packet accepted for dispatch this cycle |
| bar_met | output | 1 | Barrier resolved this cycle |

## Verification
The bench returns barrier responses in shuffled orders and checks that `bar_met` stays low until the last response is back. A design that counted responses wrongly would release the queue early. It also sends completions without the last flag during an ordering hold, which a design releasing on any completion would let through. Non-zero signal values drive the back-off path, and a design without a retry would stall forever. An unmap placed between partial responses checks that late data is dropped and that barriers are refused while draining; a design that lost the drain count would accept a barrier while stale responses can still corrupt it. Random kernel streams with random ordering flags and completions are compared every cycle against an open/held model.

// File: rtl/qbar_pkg.sv
package qbar_pkg;

    typedef enum logic [1:0] {
        Q_OPEN     = 2'd0,
        Q_HOLD_BIT = 2'd1,
        Q_HOLD_PKT = 2'd2
    } qstate_t;

    typedef enum logic {
        PH_GATHER  = 1'b0,
        PH_BACKOFF = 1'b1
    } bphase_t;

    typedef enum logic [1:0] {
        G_IDLE    = 2'd0,
        G_ISSUE   = 2'd1,
        G_COLLECT = 2'd2
    } gstate_t;

    localparam logic [1:0] PT_INVALID = 2'd0;
    localparam logic [1:0] PT_KERNEL  = 2'd1;
    localparam logic [1:0] PT_BARRIER = 2'd2;
    localparam logic [1:0] PT_AGENT   = 2'd3;

endpackage

// File: rtl/qbar_backoff.sv
module qbar_backoff #(
    parameter int RETRY = 8,
    localparam int TW = $clog2(RETRY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clr,
    output logic expire
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (start)
            cnt_q <= TW'(RETRY);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == TW'(1));

    // one expiry per back-off window
    assert_expire_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !expire);

endmodule

// File: rtl/qbar_sig_gather.sv
module qbar_sig_gather
    import qbar_pkg::*;
#(
    parameter int MAX_SIG = 5,
    parameter int SIG_W   = 32,
    localparam int IDX_W  = (MAX_SIG > 1) ? $clog2(MAX_SIG) : 1,
    localparam int CNT_W  = $clog2(MAX_SIG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] go_cnt,
    input  logic             unmap,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic [SIG_W-1:0] rsp_data,
    output logic             rd_req,
    output logic [IDX_W-1:0] rd_idx,
    output logic             all_read,
    output logic             all_zero,
    output logic             discard
);

    gstate_t gst, gst_n;
    logic [IDX_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pending_q;
    logic [CNT_W-1:0] drain_q, drain_n;
    logic [MAX_SIG-1:0] zero_ok;
    logic [MAX_SIG*SIG_W-1:0] vals_flat;
    logic take, last_hit, drop;

    // request and response decode
    always_comb begin
        rd_req   = (gst == G_ISSUE) && !unmap;
        rd_idx   = ptr_q;
        last_hit = (int'(ptr_q) + 1 == int'(cnt_q));
        discard  = (drain_q != '0);
        drop     = rsp_valid && discard;
        take     = rsp_valid && !discard && (gst != G_IDLE) &&
                   (pending_q != '0) && (int'(rsp_idx) < MAX_SIG);
        all_read = (gst == G_COLLECT) && (pending_q == '0);
        all_zero = &zero_ok;
    end

    // next state of the gatherer
    always_comb begin
        gst_n = gst;
        unique case (gst)
            G_IDLE:    if (go) gst_n = (go_cnt == '0) ? G_COLLECT : G_ISSUE;
            G_ISSUE:   if (rd_req && last_hit) gst_n = G_COLLECT;
            G_COLLECT: if (go) gst_n = (go_cnt == '0) ? G_COLLECT : G_ISSUE;
            default:   gst_n = G_IDLE;
        endcase
        if (unmap) gst_n = G_IDLE;
    end

    // drain count of responses that must be dropped
    always_comb begin
        drain_n = drain_q;
        if (drop) drain_n = drain_n - 1'b1;
        if (unmap) drain_n = drain_n + pending_q - CNT_W'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gst       <= G_IDLE;
            ptr_q     <= '0;
            cnt_q     <= '0;
            pending_q <= '0;
            drain_q   <= '0;
        end else begin
            gst     <= gst_n;
            drain_q <= drain_n;
            if (go) begin
                ptr_q <= '0;
                cnt_q <= go_cnt;
            end else if (rd_req) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (unmap)
                pending_q <= '0;
            else
                pending_q <= pending_q + CNT_W'(rd_req) - CNT_W'(take);
        end
    end

    // one slot per dependency signal
    for (genvar i = 0; i < MAX_SIG; i++) begin : g_slot
        logic [SIG_W-1:0] val_q;
        logic             used_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q  <= SIG_W'(1);
                used_q <= 1'b0;
            end else if (go) begin
                val_q  <= SIG_W'(1);
                used_q <= (i < int'(go_cnt));
            end else if (take && int'(rsp_idx) == i) begin
                val_q  <= rsp_data;
            end
        end
        assign zero_ok[i] = !used_q || (val_q == '0);
        assign vals_flat[i*SIG_W +: SIG_W] = val_q;
    end

    assert_pend_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending_q) <= MAX_SIG);

    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !go) |=> $stable(vals_flat));

    assert_unmap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unmap |=> (pending_q == '0 && gst == G_IDLE));

endmodule

// File: rtl/qbar_ctrl.sv
module qbar_ctrl
    import qbar_pkg::*;
#(
    parameter int MAX_SIG = 5,
    parameter int SIG_W   = 32,
    parameter int RETRY   = 8,
    localparam int IDX_W  = (MAX_SIG > 1) ? $clog2(MAX_SIG) : 1,
    localparam int CNT_W  = $clog2(MAX_SIG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [1:0]       pkt_type,
    input  logic             pkt_barrier,
    input  logic [CNT_W-1:0] pkt_nsig,
    input  logic             done_valid,
    input  logic             done_last,
    input  logic             unmap,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic [SIG_W-1:0] rsp_data,
    output logic             rd_req,
    output logic [IDX_W-1:0] rd_idx,
    output logic             disp_en,
    output logic             bar_met
);

    qstate_t st, st_n;
    bphase_t ph, ph_n;
    logic [CNT_W-1:0] nsig_q, nsig_c, go_cnt;
    logic is_bar, accept, go, retry_go, eval_done, t_start;
    logic all_read, all_zero, discard, expire;

    // packet and barrier decode
    always_comb begin
        nsig_c    = (int'(pkt_nsig) > MAX_SIG) ? CNT_W'(MAX_SIG) : pkt_nsig;
        is_bar    = (pkt_type == PT_BARRIER);
        accept    = pkt_valid && (pkt_type != PT_INVALID) && (st == Q_OPEN) &&
                    !unmap && !(is_bar && discard);
        retry_go  = (st == Q_HOLD_PKT) && (ph == PH_BACKOFF) && expire && !unmap;
        go        = (accept && is_bar) || retry_go;
        go_cnt    = (accept && is_bar) ? nsig_c : nsig_q;
        eval_done = (st == Q_HOLD_PKT) && (ph == PH_GATHER) && all_read && !unmap;
        t_start   = eval_done && !all_zero;
    end

    // next state
    always_comb begin
        st_n = st;
        ph_n = ph;
        unique case (st)
            Q_OPEN: begin
                if (accept && is_bar) begin
                    st_n = Q_HOLD_PKT;
                    ph_n = PH_GATHER;
                end else if (accept && pkt_barrier) begin
                    st_n = Q_HOLD_BIT;
                end
            end
            Q_HOLD_BIT: if (done_valid && done_last) st_n = Q_OPEN;
            Q_HOLD_PKT: begin
                unique case (ph)
                    PH_GATHER: begin
                        if (eval_done && all_zero)  st_n = Q_OPEN;
                        else if (eval_done)         ph_n = PH_BACKOFF;
                    end
                    PH_BACKOFF: if (expire) ph_n = PH_GATHER;
                    default:    ph_n = PH_GATHER;
                endcase
            end
            default: st_n = Q_OPEN;
        endcase
        if (unmap) begin
            st_n = Q_OPEN;
            ph_n = PH_GATHER;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= Q_OPEN;
            ph     <= PH_GATHER;
            nsig_q <= '0;
        end else begin
            st <= st_n;
            ph <= ph_n;
            if (accept && is_bar) nsig_q <= nsig_c;
        end
    end

    // outputs
    always_comb begin
        disp_en = accept;
        bar_met = eval_done && all_zero;
    end

    qbar_sig_gather #(.MAX_SIG(MAX_SIG), .SIG_W(SIG_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_cnt   (go_cnt),
        .unmap    (unmap),
        .rsp_valid(rsp_valid),
        .rsp_idx  (rsp_idx),
        .rsp_data (rsp_data),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx),
        .all_read (all_read),
        .all_zero (all_zero),
        .discard  (discard)
    );

    qbar_backoff #(.RETRY(RETRY)) u_backoff (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .clr   (unmap),
        .expire(expire)
    );

    assert_no_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_type == PT_INVALID) |-> !disp_en);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_HOLD_BIT && !(done_valid && done_last) && !unmap) |=> st == Q_HOLD_BIT);

    assert_hold_until_met_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_HOLD_PKT && !bar_met && !unmap) |=> st == Q_HOLD_PKT);

    assert_met_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bar_met |=> (st == Q_OPEN && !rd_req));

    assert_unmap_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unmap |=> st == Q_OPEN);

    assert_bar_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && is_bar && discard) |-> !disp_en);

endmodule

// File: tb/sim_qbar_ctrl.sv
module sim_qbar_ctrl;

    localparam int MAX_SIG = 5;
    localparam int RETRY   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [1:0]  pkt_type = 2'd0;
    logic        pkt_barrier = 1'b0;
    logic [2:0]  pkt_nsig = 3'd0;
    logic        done_valid = 1'b0;
    logic        done_last = 1'b0;
    logic        unmap = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_idx = 3'd0;
    logic [31:0] rsp_data = 32'd0;
    logic        rd_req;
    logic [2:0]  rd_idx;
    logic        disp_en;
    logic        bar_met;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    qbar_ctrl #(.MAX_SIG(MAX_SIG), .SIG_W(32), .RETRY(RETRY)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_type(pkt_type),
        .pkt_barrier(pkt_barrier), .pkt_nsig(pkt_nsig), .done_valid(done_valid),
        .done_last(done_last), .unmap(unmap), .rsp_valid(rsp_valid),
        .rsp_idx(rsp_idx), .rsp_data(rsp_data), .rd_req(rd_req), .rd_idx(rd_idx),
        .disp_en(disp_en), .bar_met(bar_met)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // first request is expected in the current cycle
    task automatic gather_reads(input int n, input string tag);
        int seen = 0;
        for (int c = 0; c < n + 2; c++) begin
            #4;
            if (rd_req) begin
                chk({tag, " read index"}, rd_idx, seen);
                seen++;
            end
            chk("R3 no dispatch while barrier waits", disp_en, 0);
            cyc();
        end
        chk({tag, " read count"}, seen, n);
    endtask

    task automatic respond(input int n, input logic [7:0] nz);
        int ord[8];
        for (int i = 0; i < 8; i++) ord[i] = i;
        for (int i = n - 1; i > 0; i--) begin
            int j;
            int t;
            j = int'($urandom_range(i, 0));
            t = ord[i]; ord[i] = ord[j]; ord[j] = t;
        end
        for (int k = 0; k < n; k++) begin
            rsp_valid = 1'b1;
            rsp_idx   = 3'(ord[k]);
            rsp_data  = nz[ord[k]] ? ($urandom | 32'd1) : 32'd0;
            #4 chk("R4 not met while reads pending", bar_met, 0);
            cyc();
        end
        rsp_valid = 1'b0;
    endtask

    task automatic run_barrier(input int n, input logic [7:0] nz, input string tag);
        int en;
        bit found;
        en = (n > MAX_SIG) ? MAX_SIG : n;
        pkt_valid = 1'b1; pkt_type = 2'd2; pkt_barrier = 1'b0; pkt_nsig = 3'(n);
        #4 chk("R3 barrier accepted", disp_en, 1);
        cyc();
        pkt_type = 2'd1;
        if (en == 0) begin
            pkt_valid = 1'b0;
            #4 chk("R6 zero-signal barrier met", bar_met, 1);
            cyc();
        end else begin
            gather_reads(en, tag);
            pkt_valid = 1'b0;
            respond(en, nz);
            if ((nz & 8'((1 << en) - 1)) != 8'd0) begin
                #4 chk("R5 non-zero signal keeps barrier", bar_met, 0);
                cyc();
                found = 1'b0;
                for (int w = 0; w < RETRY + 6 && !found; w++) begin
                    #4;
                    if (rd_req) found = 1'b1;
                    else cyc();
                end
                chk("R5 reads reissued after back-off", found, 1);
                gather_reads(en, "R5 reissue");
                respond(en, 8'd0);
            end
            #4 chk("R4 barrier met when all zero", bar_met, 1);
            cyc();
        end
        pkt_valid = 1'b1; pkt_type = 2'd1; pkt_barrier = 1'b0;
        #4 chk("R4 queue open after barrier", disp_en, 1);
        cyc();
        pkt_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit m_open;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #4;
        chk("R1 reset disp_en", disp_en, 0);
        chk("R1 reset rd_req", rd_req, 0);
        chk("R1 reset bar_met", bar_met, 0);
        cyc();

        // R1 type decode
        pkt_valid = 1'b1; pkt_type = 2'd0;
        #4 chk("R1 invalid type refused", disp_en, 0);
        cyc();
        pkt_type = 2'd3;
        #4 chk("R1 agent type accepted", disp_en, 1);
        cyc();
        pkt_type = 2'd1;
        #4 chk("R1 kernel type accepted", disp_en, 1);
        cyc();

        // R2 ordering flag hold
        pkt_barrier = 1'b1;
        #4 chk("R2 flagged packet accepted", disp_en, 1);
        cyc();
        pkt_barrier = 1'b0;
        #4 chk("R2 blocked after flag", disp_en, 0);
        cyc();
        done_valid = 1'b1; done_last = 1'b0;
        #4 chk("R2 blocked during non-last completion", disp_en, 0);
        cyc();
        done_valid = 1'b0;
        #4 chk("R2 non-last completion does not release", disp_en, 0);
        cyc();
        done_valid = 1'b1; done_last = 1'b1;
        #4 chk("R2 blocked in release cycle", disp_en, 0);
        cyc();
        done_valid = 1'b0; done_last = 1'b0;
        #4 chk("R2 released after last completion", disp_en, 1);
        cyc();

        // R9 unmap wins over a packet
        unmap = 1'b1;
        #4 chk("R9 packet refused with unmap", disp_en, 0);
        cyc();
        unmap = 1'b0;
        #4 chk("R9 packet accepted next cycle", disp_en, 1);
        cyc();
        pkt_valid = 1'b0;

        // barrier evaluations
        run_barrier(2, 8'd0, "R3");
        run_barrier(5, 8'd0, "R3");
        run_barrier(3, 8'b010, "R3");
        run_barrier(0, 8'd0, "R6");
        run_barrier(7, 8'd0, "R6 clamp");

        // R7 and R8 unmap with reads outstanding
        pkt_valid = 1'b1; pkt_type = 2'd2; pkt_nsig = 3'd3;
        #4 chk("R3 barrier accepted", disp_en, 1);
        cyc();
        pkt_valid = 1'b0;
        gather_reads(3, "R3");
        rsp_valid = 1'b1; rsp_idx = 3'd1; rsp_data = 32'd0;
        cyc();
        rsp_valid = 1'b0;
        unmap = 1'b1;
        #4 chk("R7 no read with unmap", rd_req, 0);
        cyc();
        unmap = 1'b0;
        pkt_valid = 1'b1; pkt_type = 2'd2; pkt_nsig = 3'd3;
        #4 chk("R8 barrier refused while draining", disp_en, 0);
        chk("R7 no reads after unmap", rd_req, 0);
        cyc();
        pkt_type = 2'd1; pkt_barrier = 1'b0;
        #4 chk("R7 kernel accepted after unmap", disp_en, 1);
        cyc();
        pkt_type = 2'd2;
        rsp_valid = 1'b1; rsp_idx = 3'd0; rsp_data = 32'd5;
        #4 chk("R8 barrier refused, two to drain", disp_en, 0);
        chk("R8 dropped data gives no met", bar_met, 0);
        cyc();
        rsp_idx = 3'd2; rsp_data = 32'd0;
        #4 chk("R8 barrier refused, one to drain", disp_en, 0);
        chk("R8 dropped data gives no met", bar_met, 0);
        cyc();
        rsp_valid = 1'b0; pkt_valid = 1'b0;
        run_barrier(3, 8'd0, "R8 after drain");

        // random kernel stream against an open/held model
        m_open = 1'b1;
        for (int c = 0; c < 400; c++) begin
            int t;
            bit exp_en;
            t = int'($urandom % 3);
            pkt_valid   = ($urandom % 2) == 0;
            pkt_type    = (t == 2) ? 2'd3 : 2'(t);
            pkt_barrier = ($urandom % 6) == 0;
            done_valid  = ($urandom % 3) == 0;
            done_last   = ($urandom % 2) == 0;
            #4;
            exp_en = pkt_valid && m_open && (pkt_type != 2'd0);
            chk("R2 random gating", disp_en, exp_en);
            if (exp_en && pkt_barrier) m_open = 1'b0;
            else if (!m_open && done_valid && done_last) m_open = 1'b1;
            cyc();
        end
        pkt_valid = 1'b0; done_valid = 1'b0; done_last = 1'b0;
        cyc();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule